// File: doc/BRIEF.md
# Maximal-Length Pseudo-Noise Chip Generator

This block produces a binary pseudo-noise chip stream from a Fibonacci linear feedback shift register whose active length, feedback tap mask and starting state are all set at run time through a synchronous load. Each pulse on the step input advances the register by one chip. The current chip is presented both as a plain bit and as a signed ±1 value, so a spreader or despreader can multiply with it directly.

For code alignment the block raises an epoch flag whenever the register holds the state it was loaded with. It also exposes a chip index that counts strobes since the last epoch, which lets a consumer confirm full periods. The user chooses primitive tap masks; the block does not search for them.

Top module: `pn_code_gen`

## Requirements
- R1: After synchronous reset the active length is 3, the tap mask selects stages 0 and 1, the register holds 3'b111, chip_o is 1, epoch_o is 1 and chip_idx_o is 0.
- R2: A load pulse captures length, tap mask and seed in one cycle; from the next cycle chip_idx_o is 0, epoch_o is 1 and chip_o equals bit 0 of the masked seed. A load takes priority over a step presented in the same cycle.
- R3: A seed whose low m bits are all zero is replaced by m ones.
- R4: Each step shifts the register toward bit 0, chip_o is register bit 0, and the new bit m−1 is the XOR of the register bits selected by the tap mask (tap bit i selects stage i; bit 0 is always forced on). Without a step or load the register, chip_o and chip_idx_o hold.
- R5: With a primitive tap mask, epoch_o returns after exactly 2^m − 1 steps.
- R6: Over one such period exactly 2^(m−1) chips are 1.
- R7: With chip 0 mapped to +1 and chip 1 to −1, the periodic correlation sum over one period is L at lag 0 and −1 at every other lag (L = 2^m − 1).
- R8: sign_o is 2'b01 (+1) when chip_o is 0 and 2'b11 (−1) when chip_o is 1.
- R9: chip_idx_o counts steps since the last epoch and returns to 0 on the step that re-enters the seed state.
- R10: A requested length below 3 is used as 3 and one above 16 as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture length, taps and seed |
| len_i | input | 5 | Requested register length m |
| taps_i | input | 16 | Feedback tap mask, bit i = stage i |
| seed_i | input | 16 | Starting state (low m bits used) |
| step_i | input | 1 | Chip strobe |
| chip_o | output | 1 | Current chip |
| sign_o | output | 2 | Current chip as signed ±1 |
| epoch_o | output | 1 | Register equals the loaded seed |
| chip_idx_o | output | 16 | Steps since the last epoch |

## Verification
The assertions assume the register is only ever loaded through load_i, so that stages above the active length stay clear and the state never becomes zero; forcing tap bit 0 makes every next-state map invertible, which is what lets the chip index stay below 2^m − 1 for any mask. Period, balance and correlation properties further assume a primitive tap mask, so the stimulus loads only known primitive masks (m = 3, 4, 5, 7, 16) when it checks them and reserves non-primitive or out-of-range settings for the clamp and ordering tests.

// File: rtl/pn_pkg.sv
// Shared helpers for the PN chip generator.
// Assumes lengths are small unsigned integers.
package pn_pkg;
    // Bound a requested register length into the supported range.
    function automatic int unsigned pn_clamp(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction
endpackage

// File: rtl/pn_lfsr_core.sv
// Fibonacci shift register with run-time length, taps and seed.
// Shifts toward bit 0; the feedback parity enters at bit len-1.
// Assumes state is only written via load, so bits at and above len stay 0.
module pn_lfsr_core
    import pn_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 3,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [MAX_LEN-1:0] taps_i,
    input  logic [MAX_LEN-1:0] seed_i,
    output logic [MAX_LEN-1:0] state_o,
    output logic [MAX_LEN-1:0] next_o,
    output logic [MAX_LEN-1:0] seed_o,
    output logic [LEN_W-1:0]   len_o
);
    localparam logic [MAX_LEN-1:0] RST_TAPS = MAX_LEN'(3);
    localparam logic [MAX_LEN-1:0] RST_SEED = MAX_LEN'(7);

    logic [MAX_LEN-1:0] state_q, taps_q, seed_q, nxt;
    logic [MAX_LEN-1:0] req_mask, req_seed, eff_seed;
    logic [LEN_W-1:0]   len_q, req_len;
    logic               fb;

    // Clamp the requested length and build the load-time mask and seed.
    always_comb begin
        req_len = LEN_W'(pn_clamp(int'(len_i), MIN_LEN, MAX_LEN));
        for (int i = 0; i < MAX_LEN; i++) req_mask[i] = (i < int'(req_len));
        req_seed = seed_i & req_mask;
        eff_seed = (req_seed == '0) ? req_mask : req_seed;
    end

    // Feedback parity over the selected stages.
    assign fb = ^(state_q & taps_q);

    // Per-stage next-state selection: feedback enters at len-1, others shift down.
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_stage
        if (i == MAX_LEN - 1) begin : g_top
            assign nxt[i] = (int'(len_q) == i + 1) ? fb : 1'b0;
        end else begin : g_mid
            assign nxt[i] = (int'(len_q) == i + 1) ? fb : state_q[i+1];
        end
    end

    // Configuration capture and register advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= LEN_W'(MIN_LEN);
            taps_q  <= RST_TAPS;
            seed_q  <= RST_SEED;
            state_q <= RST_SEED;
        end else if (load_i) begin
            len_q   <= req_len;
            taps_q  <= (taps_i & req_mask) | MAX_LEN'(1);
            seed_q  <= eff_seed;
            state_q <= eff_seed;
        end else if (step_i) begin
            state_q <= nxt;
        end
    end

    assign state_o = state_q;
    assign next_o  = nxt;
    assign seed_o  = seed_q;
    assign len_o   = len_q;

    // R3/R4: an invertible map from a nonzero start never reaches zero.
    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != '0));
    // R10: stages at and above the active length stay clear.
    p_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q >> len_q) == '0));
    // R4: no strobe and no load leaves the register unchanged.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/pn_epoch_track.sv
// Epoch flag and chip index for the PN generator.
// Epoch is high while the register equals the loaded seed; the index
// counts strobes and clears on the strobe that re-enters the seed.
// Assumes the register map is invertible so the seed always recurs.
module pn_epoch_track #(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [MAX_LEN-1:0] state_i,
    input  logic [MAX_LEN-1:0] next_i,
    input  logic [MAX_LEN-1:0] seed_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               epoch_o,
    output logic [MAX_LEN-1:0] idx_o
);
    logic [MAX_LEN-1:0] idx_q;
    logic [MAX_LEN:0]   period;

    // Epoch compare against the captured seed.
    assign epoch_o = (state_i == seed_i);
    // Period length for the bound check.
    assign period = ((MAX_LEN+1)'(1) << len_i) - (MAX_LEN+1)'(1);

    // Chip index: clear on load or on return to the seed, else count strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)           idx_q <= '0;
        else if (load_i)      idx_q <= '0;
        else if (step_i)      idx_q <= (next_i == seed_i) ? '0 : idx_q + 1'b1;
    end

    assign idx_o = idx_q;

    // R9: whenever the seed state is present the index reads zero.
    p_epoch_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_o |-> (idx_q == '0));
    // R2: a load leaves the index at zero on the following cycle.
    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_q == '0) && epoch_o);
    // R5: the index never reaches the period length.
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, idx_q} < period));
endmodule

// File: rtl/pn_code_gen.sv
// Top of the PN chip generator: register core, epoch tracker and
// ±1 sign mapping. Assumes primitive tap masks for full-period use.
module pn_code_gen #(
    parameter int MAX_LEN = 16,
    parameter int MIN_LEN = 3,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [MAX_LEN-1:0] taps_i,
    input  logic [MAX_LEN-1:0] seed_i,
    input  logic               step_i,
    output logic               chip_o,
    output logic [1:0]         sign_o,
    output logic               epoch_o,
    output logic [MAX_LEN-1:0] chip_idx_o
);
    logic [MAX_LEN-1:0] state, nxt, seed;
    logic [LEN_W-1:0]   len;

    pn_lfsr_core #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .len_i(len_i), .taps_i(taps_i), .seed_i(seed_i),
        .state_o(state), .next_o(nxt), .seed_o(seed), .len_o(len)
    );

    pn_epoch_track #(.MAX_LEN(MAX_LEN)) u_epoch (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .state_i(state), .next_i(nxt), .seed_i(seed), .len_i(len),
        .epoch_o(epoch_o), .idx_o(chip_idx_o)
    );

    // Output chip and its signed ±1 form.
    assign chip_o = state[0];
    assign sign_o = chip_o ? 2'b11 : 2'b01;

    // R8: sign is +1 for a zero chip and -1 for a one chip.
    p_sign_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_o == (state[0] ? 2'b11 : 2'b01)) && (sign_o[0] == 1'b1));
endmodule

// File: tb/pn_code_gen_test.sv
`timescale 1ns/1ps
module pn_code_gen_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        load_i = 0;
    logic [4:0]  len_i = 0;
    logic [15:0] taps_i = 0;
    logic [15:0] seed_i = 0;
    logic        step_i = 0;
    logic        chip_o;
    logic [1:0]  sign_o;
    logic        epoch_o;
    logic [15:0] chip_idx_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic cbuf [0:63];

    always #2.5 clk = ~clk;

    pn_code_gen uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .len_i(len_i),
        .taps_i(taps_i), .seed_i(seed_i), .step_i(step_i),
        .chip_o(chip_o), .sign_o(sign_o), .epoch_o(epoch_o),
        .chip_idx_o(chip_idx_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int len, input int taps, input int seed);
        len_i = 5'(len); taps_i = 16'(taps); seed_i = 16'(seed); load_i = 1;
        @(posedge clk); #1; load_i = 0;
    endtask

    task automatic do_step();
        step_i = 1;
        @(posedge clk); #1; step_i = 0;
    endtask

    // R1: state straight after reset.
    task automatic t_reset();
        chk(chip_o == 1'b1, "R1 chip", int'(chip_o), 1);
        chk(epoch_o == 1'b1, "R1 epoch", int'(epoch_o), 1);
        chk(chip_idx_o == 0, "R1 idx", int'(chip_idx_o), 0);
        // R1 reset taps {0,1}, length 3 -> period 7
        begin
            int n = 0;
            do begin do_step(); n++; end while (!epoch_o && n < 20);
            chk(n == 7, "R1 reset period", n, 7);
        end
    endtask

    // R4: shift/feedback sequence and hold without strobe.
    task automatic t_sequence();
        bit exp_seq [0:6] = '{1, 0, 0, 1, 0, 1, 1};
        do_load(3, 3, 1);
        for (int k = 0; k < 10; k++) begin
            chk(chip_o == exp_seq[k % 7], "R4 chip sequence", int'(chip_o), int'(exp_seq[k % 7]));
            do_step();
        end
        begin
            logic c0; logic [15:0] i0;
            c0 = chip_o; i0 = chip_idx_o;
            repeat (4) @(posedge clk);
            #1;
            chk(chip_o == c0 && chip_idx_o == i0, "R4 hold", int'(chip_idx_o), int'(i0));
        end
    endtask

    // R2: load outranks a simultaneous step.
    task automatic t_load_priority();
        do_step(); do_step();
        step_i = 1;
        do_load(3, 3, 2);
        step_i = 0;
        chk(chip_o == 1'b0 && epoch_o, "R2 load wins chip", int'(chip_o), 0);
        chk(chip_idx_o == 0, "R2 idx cleared", int'(chip_idx_o), 0);
        do_step();
        chk(chip_o == 1'b1, "R2 first step", int'(chip_o), 1);
        chk(chip_idx_o == 1, "R2 idx one", int'(chip_idx_o), 1);
    endtask

    // R5/R6/R8/R9: one full period from the seed.
    task automatic t_period(input int m, input string tag);
        int p, n, ones;
        bit idx_ok, sign_ok;
        p = (1 << m) - 1;
        n = 0; ones = 0; idx_ok = 1; sign_ok = 1;
        do begin
            if (chip_idx_o != 16'(n)) idx_ok = 0;
            if (sign_o != (chip_o ? 2'b11 : 2'b01)) sign_ok = 0;
            if (n < 64) cbuf[n] = chip_o;
            if (chip_o) ones++;
            do_step(); n++;
        end while (!epoch_o && n < p + 5);
        chk(n == p, {"R5 period ", tag}, n, p);
        chk(ones == (1 << (m - 1)), {"R6 ones ", tag}, ones, 1 << (m - 1));
        chk(idx_ok && chip_idx_o == 0, {"R9 index ", tag}, int'(chip_idx_o), 0);
        chk(sign_ok, {"R8 sign ", tag}, int'(sign_ok), 1);
    endtask

    // R3: zero seed turns into all ones.
    task automatic t_zero_seed();
        do_load(4, 3, 0);
        chk(chip_o == 1'b1 && epoch_o, "R3 zero seed chip", int'(chip_o), 1);
        for (int k = 0; k < 3; k++) do_step();
        chk(chip_o == 1'b1, "R3 bit3 of seed", int'(chip_o), 1);
        do_load(4, 3, 0);
        t_period(4, "m4");
    endtask

    // R7: periodic correlation of the ±1 sequence for m=5.
    task automatic t_autocorr();
        bit ok = 1; int bad = 0; int badlag = 0;
        do_load(5, 5, 1);
        t_period(5, "m5");
        for (int lag = 0; lag < 31; lag++) begin
            int s = 0;
            for (int k = 0; k < 31; k++)
                s += (cbuf[k] == cbuf[(k + lag) % 31]) ? 1 : -1;
            if (s != ((lag == 0) ? 31 : -1)) begin ok = 0; bad = s; badlag = lag; end
        end
        chk(ok, "R7 autocorrelation", bad, badlag == 0 ? 31 : -1);
    endtask

    // R10: out-of-range lengths are clamped.
    task automatic t_clamp();
        do_load(1, 3, 7);
        t_period(3, "clamp low");
        do_load(31, 'h002D, 'h8000);
        for (int k = 0; k < 15; k++) do_step();
        chk(chip_o == 1'b1, "R10 clamp high bit15", int'(chip_o), 1);
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre();
        rst_n = 1;
        t_reset();
        t_sequence();
        t_load_priority();
        do_load(3, 3, 1);   t_period(3, "m3");
        t_zero_seed();
        t_autocorr();
        do_load(7, 3, 'h55); t_period(7, "m7");
        do_load(16, 'h002D, 1); t_period(16, "m16");
        t_clamp();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // R1: outputs while reset is held.
    task automatic t_reset_pre();
        chk(chip_o == 1'b1 && epoch_o && chip_idx_o == 0, "R1 in reset",
            int'(chip_idx_o), 0);
    endtask
endmodule